// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one output-compare channel of a timer. It watches one of several free-running time base buses and compares the selected value with a programmed 16-bit match value. When the two become equal, the channel sets a sticky match flag, can request an interrupt, and acts on its output pin according to a 2-bit mode. In level mode the pin takes a programmed level. In toggle mode the pin inverts. In port mode the pin follows the level bit directly, and matches only set the flag. In off mode the comparator is idle.

Software reaches the channel through a small register bus with two words: a control/status word and the match value. A force strobe in the control word performs the mode's pin action without a real match. A match is recognised once, on the first cycle in which the selected bus equals the match value. A bus that stays at that value for many cycles therefore produces one event, not a stream of them.

Top module: `tmr_oc_chan`

## Requirements
- R1: After reset the control word reads 0 (mode off, time base 0, interrupt enable 0, level 0, flag 0), the match word reads 0, and pin_o and irq_o are 0.
- R2: A match event occurs on a cycle in which the selected time base (control bit 8: 0 picks tb_i[0], 1 picks tb_i[1]) equals the match word and did not equal it in the cycle before. The flag (control bit 5) is set at the next clock edge. A bus held at the match value yields only one event, and a match on the unselected bus has no effect.
- R3: irq_o is 1 exactly when the flag and the interrupt enable (control bit 2) are both 1.
- R4: The flag is sticky. It is cleared only by a control write with bit 5 = 0 that follows a read of the control word which returned the flag as 1. A write without such a read, or a write with bit 5 = 1, leaves the flag set. Any control write consumes the armed read.
- R5: If a match event falls in the same cycle as a valid clear write, the flag stays set.
- R6: In level mode (mode field, bits 1:0 = 1), a match event loads the level bit (control bit 3) into the output flip-flop that drives pin_o.
- R7: In toggle mode (mode = 2), each match event inverts the output flip-flop.
- R8: A control write with bit 4 = 1 performs the mode's pin action at the clock edge after the write, without setting the flag. Bit 4 always reads 0.
- R9: A force and a match event in the same cycle in toggle mode give a single inversion, and the flag is set.
- R10: In port mode (mode = 3), pin_o equals the level bit from the write edge on. Match events set the flag, but neither matches nor forces change the output flip-flop.
- R11: In off mode (mode = 0) there are no match events, the flag is not set, and a force has no effect on pin_o.
- R12: Control bit 6 reads the current pin_o value, and bit 3 reads the last level written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tb_i | input | 2x16 | Time base buses, packed, index 0 in the low half |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (arms flag clearing) |
| addr_i | input | 1 | Word select: 0 control/status, 1 match value |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| pin_o | output | 1 | Channel output pin |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets the places where pin action and flag handling can drift apart. A force that lands on the same edge as a real match is one case: a design that adds the two toggles leaves the pin unchanged, and one that ignores the match leaves the flag clear. A clear write that meets a match is another: the flag must survive. The bench also writes clears that were never armed by a read, and it holds the time base at the match value for several cycles, where a level-sensitive comparator would make the pin oscillate. Port and off modes are probed with both matches and forces to show the output flip-flop stays put, and the one-cycle force latency is sampled on both sides of the acting edge.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_LVL  = 2'd1,
    MODE_TOG  = 2'd2,
    MODE_PORT = 2'd3
  } oc_mode_e;

  localparam logic ADDR_CTL = 1'b0;
  localparam logic ADDR_CMP = 1'b1;

  localparam int CTL_MODE_LSB = 0;
  localparam int CTL_IEN      = 2;
  localparam int CTL_LVL      = 3;
  localparam int CTL_FRC      = 4;
  localparam int CTL_FLAG     = 5;
  localparam int CTL_PIN      = 6;
  localparam int CTL_SEL_LSB  = 8;
endpackage

// File: rtl/oc_cmp.sv
module oc_cmp #(
  parameter int TW     = 16,
  parameter int NUM_TB = 2,
  parameter int SEL_W  = 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_TB-1:0][TW-1:0]    tb_i,
  input  logic [SEL_W-1:0]             sel_i,
  input  logic [TW-1:0]                cmp_i,
  input  logic                         en_i,
  output logic                         match_o
);
  logic [TW-1:0] tb_cur;
  logic          eq, eq_q;

  always_comb begin
    tb_cur = '0;
    for (int i = 0; i < NUM_TB; i++) begin
      if (sel_i == SEL_W'(i)) tb_cur = tb_i[i];
    end
  end

  assign eq = en_i && (tb_cur == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_q <= 1'b0;
    else         eq_q <= eq;
  end

  // one event per entry into equality
  assign match_o = eq && !eq_q;
endmodule

// File: rtl/oc_regs.sv
module oc_regs
  import oc_pkg::*;
#(
  parameter int TW    = 16,
  parameter int SEL_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             re_i,
  input  logic             addr_i,
  input  logic [TW-1:0]    wdata_i,
  input  logic             match_i,
  input  logic             pin_i,
  output logic [TW-1:0]    rdata_o,
  output oc_mode_e         mode_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             ien_o,
  output logic             lvl_o,
  output logic [TW-1:0]    cmp_o,
  output logic             force_o,
  output logic             flag_o
);
  logic ctl_we, ctl_re, cmp_we;
  logic armed_q;
  oc_mode_e mode_wr;

  assign ctl_we  = we_i && (addr_i == ADDR_CTL);
  assign cmp_we  = we_i && (addr_i == ADDR_CMP);
  assign ctl_re  = re_i && (addr_i == ADDR_CTL);
  assign mode_wr = oc_mode_e'(wdata_i[CTL_MODE_LSB +: 2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_OFF;
      sel_o  <= '0;
      ien_o  <= 1'b0;
      lvl_o  <= 1'b0;
    end else if (ctl_we) begin
      mode_o <= mode_wr;
      sel_o  <= wdata_i[CTL_SEL_LSB +: SEL_W];
      ien_o  <= wdata_i[CTL_IEN];
      lvl_o  <= wdata_i[CTL_LVL];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmp_o <= '0;
    else if (cmp_we) cmp_o <= wdata_i;
  end

  // force acts one edge after the write, with the new mode and level in place
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) force_o <= 1'b0;
    else         force_o <= ctl_we && wdata_i[CTL_FRC] && (mode_wr != MODE_OFF);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                armed_q <= 1'b0;
    else if (ctl_we)            armed_q <= 1'b0;
    else if (ctl_re && flag_o)  armed_q <= 1'b1;
  end

  // a match on the clearing edge wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        flag_o <= 1'b0;
    else if (match_i)                                   flag_o <= 1'b1;
    else if (ctl_we && armed_q && !wdata_i[CTL_FLAG])   flag_o <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CMP) begin
      rdata_o = cmp_o;
    end else begin
      rdata_o[CTL_MODE_LSB +: 2]     = mode_o;
      rdata_o[CTL_IEN]               = ien_o;
      rdata_o[CTL_LVL]               = lvl_o;
      rdata_o[CTL_FLAG]              = flag_o;
      rdata_o[CTL_PIN]               = pin_i;
      rdata_o[CTL_SEL_LSB +: SEL_W]  = sel_o;
    end
  end
endmodule

// File: rtl/oc_out.sv
module oc_out
  import oc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  oc_mode_e mode_i,
  input  logic     lvl_i,
  input  logic     match_i,
  input  logic     force_i,
  output logic     ff_o,
  output logic     pin_o
);
  logic act;
  assign act = match_i || force_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff_o <= 1'b0;
    end else if (act) begin
      unique case (mode_i)
        MODE_LVL: ff_o <= lvl_i;
        MODE_TOG: ff_o <= !ff_o;
        default:  ff_o <= ff_o;
      endcase
    end
  end

  assign pin_o = (mode_i == MODE_PORT) ? lvl_i : ff_o;
endmodule

// File: rtl/tmr_oc_chan.sv
module tmr_oc_chan
  import oc_pkg::*;
#(
  parameter int TW     = 16,
  parameter int NUM_TB = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_TB-1:0][TW-1:0] tb_i,
  input  logic                      we_i,
  input  logic                      re_i,
  input  logic                      addr_i,
  input  logic [TW-1:0]             wdata_i,
  output logic [TW-1:0]             rdata_o,
  output logic                      pin_o,
  output logic                      irq_o
);
  localparam int SEL_W = (NUM_TB > 1) ? $clog2(NUM_TB) : 1;

  oc_mode_e         mode_q;
  logic [SEL_W-1:0] sel_q;
  logic             ien_q, lvl_q, flag_q, force_q, ff_q, match_evt;
  logic [TW-1:0]    cmp_q;

  oc_cmp #(.TW(TW), .NUM_TB(NUM_TB), .SEL_W(SEL_W)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tb_i    (tb_i),
    .sel_i   (sel_q),
    .cmp_i   (cmp_q),
    .en_i    (mode_q != MODE_OFF),
    .match_o (match_evt)
  );

  oc_regs #(.TW(TW), .SEL_W(SEL_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .re_i    (re_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .match_i (match_evt),
    .pin_i   (pin_o),
    .rdata_o (rdata_o),
    .mode_o  (mode_q),
    .sel_o   (sel_q),
    .ien_o   (ien_q),
    .lvl_o   (lvl_q),
    .cmp_o   (cmp_q),
    .force_o (force_q),
    .flag_o  (flag_q)
  );

  oc_out u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_q),
    .lvl_i   (lvl_q),
    .match_i (match_evt),
    .force_i (force_q),
    .ff_o    (ff_q),
    .pin_o   (pin_o)
  );

  assign irq_o = flag_q && ien_q;
endmodule

// File: rtl/tmr_oc_chan_chk.sv
module tmr_oc_chan_chk
  import oc_pkg::*;
#(
  parameter int TW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic          addr_i,
  input logic [TW-1:0] wdata_i,
  input logic          irq_o,
  input logic [1:0]    mode_i,
  input logic          lvl_i,
  input logic          ien_i,
  input logic          flag_i,
  input logic          ff_i,
  input logic          match_i
);
  assert_irq_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_i && ien_i));

  assert_flag_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_i) |-> $past(we_i && (addr_i == ADDR_CTL) && !wdata_i[CTL_FLAG]));

  assert_flag_by_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> $past(match_i));

  assert_lvl_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode_i == MODE_LVL && match_i) |-> (ff_i == $past(lvl_i)));

  assert_toggle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode_i == MODE_TOG && match_i) |-> (ff_i != $past(ff_i)));

  assert_port_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_PORT && $past(mode_i == MODE_PORT)) |-> $stable(ff_i));

  assert_off_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF) |-> !match_i);
endmodule

bind tmr_oc_chan tmr_oc_chan_chk #(.TW(TW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .mode_i  (mode_q),
  .lvl_i   (lvl_q),
  .ien_i   (ien_q),
  .flag_i  (flag_q),
  .ff_i    (ff_q),
  .match_i (match_evt)
);

// File: tb/tmr_oc_chan_tb.sv
module tmr_oc_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tb0 = 16'h0000, tb1 = 16'h0000;
  logic [1:0][15:0] tb_bus;
  logic        we = 1'b0, re = 1'b0, addr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pin, irq;
  int total = 0, bad = 0;
  bit done = 0;

  localparam logic [15:0] CMPV = 16'h1234;

  assign tb_bus = {tb1, tb0};
  always #2 clk = ~clk;

  tmr_oc_chan u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tb_i(tb_bus), .we_i(we), .re_i(re),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pin_o(pin), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    @(negedge clk); addr = a; re = 1'b1; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic pulse0();
    @(negedge clk); tb0 = CMPV;
    @(negedge clk); tb0 = 16'h0000;
  endtask

  task automatic clr_flag(input logic [15:0] ctl);
    logic [15:0] d;
    rd(1'b0, d);
    wr(1'b0, ctl & ~16'h0020);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 pin", {15'd0, pin}, 16'd0);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    rd(1'b0, d); chk("R1 ctl", d, 16'h0000);
    rd(1'b1, d); chk("R1 cmp", d, 16'h0000);
  endtask

  task automatic t_level();
    logic [15:0] d;
    wr(1'b1, CMPV);
    wr(1'b0, 16'h0009);
    chk("R6 pin before match", {15'd0, pin}, 16'd0);
    pulse0();
    chk("R6 pin after match", {15'd0, pin}, 16'd1);
    rd(1'b0, d);
    chk("R2 flag set", {15'd0, d[5]}, 16'd1);
    chk("R12 pin bit", {15'd0, d[6]}, 16'd1);
    chk("R12 lvl bit", {15'd0, d[3]}, 16'd1);
  endtask

  task automatic t_clear();
    logic [15:0] d;
    // flag armed by the last read; write of 1 consumes it
    wr(1'b0, 16'h0029);
    wr(1'b0, 16'h0009);
    rd(1'b0, d); chk("R4 unarmed clear ignored", {15'd0, d[5]}, 16'd1);
    wr(1'b0, 16'h0009);
    rd(1'b0, d); chk("R4 armed clear", {15'd0, d[5]}, 16'd0);
  endtask

  task automatic t_irq();
    wr(1'b0, 16'h000D);
    chk("R3 irq idle", {15'd0, irq}, 16'd0);
    pulse0();
    chk("R3 irq raised", {15'd0, irq}, 16'd1);
    wr(1'b0, 16'h0009);
    chk("R3 irq masked", {15'd0, irq}, 16'd0);
    clr_flag(16'h0009);
  endtask

  task automatic t_toggle();
    logic [15:0] d;
    wr(1'b0, 16'h0002);                       // toggle, pin currently 1
    @(negedge clk); tb0 = CMPV;
    repeat (4) @(negedge clk);
    tb0 = 16'h0000;
    chk("R2 held match single toggle", {15'd0, pin}, 16'd0);
    pulse0();
    chk("R7 second toggle", {15'd0, pin}, 16'd1);
    wr(1'b0, 16'h0102);                       // select tb1
    pulse0();
    chk("R2 unselected bus ignored", {15'd0, pin}, 16'd1);
    @(negedge clk); tb1 = CMPV;
    @(negedge clk); tb1 = 16'h0000;
    chk("R2 tb1 match toggles", {15'd0, pin}, 16'd0);
    wr(1'b0, 16'h0002);
    clr_flag(16'h0002);
    rd(1'b0, d); chk("R4 flag cleared", {15'd0, d[5]}, 16'd0);
  endtask

  task automatic t_force();
    logic [15:0] d;
    wr(1'b0, 16'h0019);                       // level mode, lvl 1, force; pin 0
    chk("R8 force not yet", {15'd0, pin}, 16'd0);
    @(negedge clk);
    chk("R8 force level", {15'd0, pin}, 16'd1);
    rd(1'b0, d);
    chk("R8 no flag", {15'd0, d[5]}, 16'd0);
    chk("R8 force reads 0", {15'd0, d[4]}, 16'd0);
    wr(1'b0, 16'h0012);
    @(negedge clk);
    chk("R8 force toggle", {15'd0, pin}, 16'd0);
  endtask

  task automatic t_coincide();
    logic [15:0] d;
    @(negedge clk); addr = 1'b0; wdata = 16'h0012; we = 1'b1;
    @(negedge clk); we = 1'b0; tb0 = CMPV;
    @(negedge clk); tb0 = 16'h0000;
    chk("R9 single toggle", {15'd0, pin}, 16'd1);
    rd(1'b0, d);
    chk("R9 flag set", {15'd0, d[5]}, 16'd1);
  endtask

  task automatic t_race();
    logic [15:0] d;
    // armed by the read in t_coincide
    @(negedge clk); addr = 1'b0; wdata = 16'h0002; we = 1'b1; tb0 = CMPV;
    @(negedge clk); we = 1'b0; tb0 = 16'h0000;
    rd(1'b0, d);
    chk("R5 match beats clear", {15'd0, d[5]}, 16'd1);
    chk("R7 toggled on race", {15'd0, pin}, 16'd0);
    wr(1'b0, 16'h0002);
    rd(1'b0, d); chk("R4 clear after race", {15'd0, d[5]}, 16'd0);
  endtask

  task automatic t_port();
    logic [15:0] d;
    wr(1'b0, 16'h000B);
    chk("R10 pin follows lvl 1", {15'd0, pin}, 16'd1);
    pulse0();
    chk("R10 match no pin change", {15'd0, pin}, 16'd1);
    rd(1'b0, d); chk("R10 flag set", {15'd0, d[5]}, 16'd1);
    wr(1'b0, 16'h0003);
    chk("R10 pin follows lvl 0", {15'd0, pin}, 16'd0);
    rd(1'b0, d); chk("R12 pin bit port", {15'd0, d[6]}, 16'd0);
    wr(1'b0, 16'h0003);
    wr(1'b0, 16'h0013);
    @(negedge clk);
    chk("R10 force no pin change", {15'd0, pin}, 16'd0);
    wr(1'b0, 16'h0002);                       // back to toggle: flip-flop kept 0
    chk("R10 flip-flop held", {15'd0, pin}, 16'd0);
  endtask

  task automatic t_off();
    logic [15:0] d;
    wr(1'b0, 16'h0008);
    pulse0();
    rd(1'b0, d);
    chk("R11 no flag", {15'd0, d[5]}, 16'd0);
    chk("R11 pin held", {15'd0, pin}, 16'd0);
    wr(1'b0, 16'h0018);
    @(negedge clk);
    chk("R11 force ignored", {15'd0, pin}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_level();
    t_clear();
    t_irq();
    t_toggle();
    t_force();
    t_coincide();
    t_race();
    t_port();
    t_off();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule